// File: doc/BRIEF.md
# Configurable Watchdog Timer with Paired Clear

The block counts cycles of a watchdog clock and raises a one-cycle time-out pulse, meant to reset the device, when software fails to restart the count in time. The time-out length is a power of two from 2^8 to 2^11 cycles, chosen by a static 2-bit exponent code. A static enable turns the whole timer on or off.

Software restarts the count in one of two ways, picked by a static mode bit. In single-clear mode, one clear strobe is enough. In paired-clear mode, two distinct clear strobes (call them A and B) must both be seen, in either order or on the same cycle. Only then does the count restart. This guards against a single runaway instruction that keeps the timer fed.

The paired-clear tracker is a small state machine with three states:
- `CLR_IDLE`: nothing pending.
- `CLR_HAVE_A`: only A seen.
- `CLR_HAVE_B`: only B seen.

Its transitions are:
- idle→have-A on A alone.
- idle→have-B on B alone.
- have-A→idle on B (pair complete).
- have-B→idle on A (pair complete).
- idle→idle on A and B together (pair complete).
- any state→idle when the tracker is disarmed.

The counter runs a second state machine with two states, `RUN_OFF` and `RUN_ON`. It enters `RUN_ON` when enabled and returns to `RUN_OFF` when disabled.

Top module: `wdog_timer`

## Requirements
- R1: With exponent code `exp_sel` = k (0..3), n = 8 + k. With no clears, `tmo_pulse` is high once every 2^n cycles. The first pulse is sampled 2^n cycles after reset is released.
- R2: `tmo_pulse` lasts exactly one cycle, and the count then restarts from zero.
- R3: While `en_cfg` is 0, `tmo_pulse` stays 0 and the count is held at zero. After re-enabling, a full 2^n cycles pass before the next pulse.
- R4: In single-clear mode (`dual_mode` = 0), `clr_single` restarts the count. `clr_a` and `clr_b` have no effect.
- R5: In paired-clear mode (`dual_mode` = 1), the count restarts once both `clr_a` and `clr_b` have been seen, in either order or on the same cycle. Both pending marks are then dropped.
- R6: In paired-clear mode, repeating the same strobe does not restart the count, and `clr_single` has no effect.
- R7: A clear that takes effect on the cycle the count is at 2^n - 1 suppresses the pulse, and the count restarts from zero.
- R8: Synchronous reset `rst` clears the count and both pending marks, and forces `tmo_pulse` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst | input | 1 | Synchronous reset, active high |
| en_cfg | input | 1 | Static enable |
| exp_sel | input | 2 | Exponent code, n = 8 + code |
| dual_mode | input | 1 | 0 = single-clear, 1 = paired-clear |
| clr_single | input | 1 | Clear strobe for single-clear mode |
| clr_a | input | 1 | First paired clear strobe |
| clr_b | input | 1 | Second paired clear strobe |
| tmo_pulse | output | 1 | One-cycle time-out pulse |

## Verification
The assertions check the following properties on every cycle:
- The pulse is only ever one cycle wide.
- The timer stays silent while disabled or in reset.
- An accepted clear always blocks the pulse on the following cycle.
- In paired-clear mode, a restart only happens on a cycle where one of the paired strobes is present.
- Simultaneous A and B always complete the pair.

Some behaviours can only be shown by the bench's scenarios, which compare against a cycle-by-cycle reference model:
- The exact period for each exponent code.
- That order does not matter across separate cycles.
- That a repeated lone strobe never feeds the timer.
- That a clear landing exactly on the terminal cycle wins.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        CLR_IDLE   = 2'd0,
        CLR_HAVE_A = 2'd1,
        CLR_HAVE_B = 2'd2
    } clr_state_t;

    typedef enum logic {
        RUN_OFF = 1'b0,
        RUN_ON  = 1'b1
    } run_state_t;
endpackage

// File: rtl/wdog_pair_fsm.sv
module wdog_pair_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic clr_a,
    input  logic clr_b,
    output logic pair_done
);
    clr_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= CLR_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!arm) begin
            state_d = CLR_IDLE;
        end else begin
            unique case (state_q)
                CLR_IDLE: begin
                    if (clr_a && clr_b) state_d = CLR_IDLE;
                    else if (clr_a)     state_d = CLR_HAVE_A;
                    else if (clr_b)     state_d = CLR_HAVE_B;
                end
                CLR_HAVE_A: if (clr_b) state_d = CLR_IDLE;
                CLR_HAVE_B: if (clr_a) state_d = CLR_IDLE;
                default: state_d = CLR_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        pair_done = 1'b0;
        if (arm) begin
            unique case (state_q)
                CLR_IDLE:   pair_done = clr_a && clr_b;
                CLR_HAVE_A: pair_done = clr_b;
                CLR_HAVE_B: pair_done = clr_a;
                default:    pair_done = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/wdog_term_sel.sv
module wdog_term_sel #(
    parameter int EXP_MIN   = 8,
    parameter int EXP_SEL_W = 2,
    localparam int NSEL     = 1 << EXP_SEL_W,
    localparam int CW       = EXP_MIN + NSEL - 1
) (
    input  logic [EXP_SEL_W-1:0] exp_sel,
    output logic [CW-1:0]        term
);
    logic [CW-1:0] term_tab [NSEL];

    for (genvar g = 0; g < NSEL; g++) begin : g_term
        localparam int SH = NSEL - 1 - g;
        assign term_tab[g] = {CW{1'b1}} >> SH;
    end

    assign term = term_tab[exp_sel];
endmodule

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          clr,
    input  logic [CW-1:0] term,
    output logic          tmo
);
    run_state_t    run_q, run_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          tmo_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= RUN_OFF;
            cnt_q <= '0;
            tmo   <= 1'b0;
        end else begin
            run_q <= run_d;
            cnt_q <= cnt_d;
            tmo   <= tmo_d;
        end
    end

    // transitions and counter datapath
    always_comb begin
        run_d = run_q;
        cnt_d = cnt_q;
        tmo_d = 1'b0;
        unique case (run_q)
            RUN_OFF: begin
                cnt_d = '0;
                if (en) run_d = RUN_ON;
            end
            RUN_ON: begin
                if (!en) begin
                    run_d = RUN_OFF;
                    cnt_d = '0;
                end else if (clr) begin
                    cnt_d = '0;
                end else if (cnt_q == term) begin
                    cnt_d = '0;
                    tmo_d = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                run_d = RUN_OFF;
                cnt_d = '0;
            end
        endcase
    end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
    parameter int EXP_MIN   = 8,
    parameter int EXP_SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en_cfg,
    input  logic [EXP_SEL_W-1:0] exp_sel,
    input  logic                 dual_mode,
    input  logic                 clr_single,
    input  logic                 clr_a,
    input  logic                 clr_b,
    output logic                 tmo_pulse
);
    localparam int NSEL = 1 << EXP_SEL_W;
    localparam int CW   = EXP_MIN + NSEL - 1;

    logic [CW-1:0] term;
    logic          pair_done;
    logic          clr_go;

    wdog_term_sel #(.EXP_MIN(EXP_MIN), .EXP_SEL_W(EXP_SEL_W)) u_term (
        .exp_sel (exp_sel),
        .term    (term)
    );

    wdog_pair_fsm u_pair (
        .clk       (clk),
        .rst       (rst),
        .arm       (en_cfg && dual_mode),
        .clr_a     (clr_a),
        .clr_b     (clr_b),
        .pair_done (pair_done)
    );

    assign clr_go = en_cfg && (dual_mode ? pair_done : clr_single);

    wdog_count #(.CW(CW)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .en   (en_cfg),
        .clr  (clr_go),
        .term (term),
        .tmo  (tmo_pulse)
    );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
    input logic clk,
    input logic rst,
    input logic en_cfg,
    input logic dual_mode,
    input logic clr_single,
    input logic clr_a,
    input logic clr_b,
    input logic clr_go,
    input logic tmo_pulse
);
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        tmo_pulse |=> !tmo_pulse); // R2
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        !en_cfg |=> !tmo_pulse); // R3
    AST_SINGLE_CLEAR_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (en_cfg && !dual_mode && clr_single) |=> !tmo_pulse); // R4
    AST_PAIR_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (en_cfg && dual_mode && clr_a && clr_b) |-> clr_go); // R5
    AST_PAIR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        (dual_mode && clr_go) |-> (clr_a || clr_b)); // R6
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr_go |=> !tmo_pulse); // R7
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !tmo_pulse); // R8
endmodule

bind wdog_timer wdog_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .en_cfg     (en_cfg),
    .dual_mode  (dual_mode),
    .clr_single (clr_single),
    .clr_a      (clr_a),
    .clr_b      (clr_b),
    .clr_go     (clr_go),
    .tmo_pulse  (tmo_pulse)
);

// File: tb/sim_wdog_timer.sv
`timescale 1ns/1ps
module sim_wdog_timer;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_cfg = 1'b0;
    logic [1:0] exp_sel = 2'd0;
    logic dual_mode = 1'b0;
    logic clr_single = 1'b0, clr_a = 1'b0, clr_b = 1'b0;
    logic tmo_pulse;

    int checks = 0, fails = 0, pulses = 0;
    string req = "R8";

    // reference model state
    int  m_cnt = 0;
    bit  m_pa = 0, m_pb = 0, m_tmo = 0;
    bit  m_on = 0;

    always #2 clk = ~clk;

    wdog_timer u0 (
        .clk(clk), .rst(rst), .en_cfg(en_cfg), .exp_sel(exp_sel),
        .dual_mode(dual_mode), .clr_single(clr_single), .clr_a(clr_a),
        .clr_b(clr_b), .tmo_pulse(tmo_pulse)
    );

    function automatic int period_of(input logic [1:0] code);
        return 1 << (8 + int'(code));
    endfunction

    // behavioural reference, updated on each edge
    always @(posedge clk) begin
        bit clr;
        bit pa, pb;
        clr = 0;
        pa = m_pa; pb = m_pb;
        if (rst) begin
            m_cnt <= 0; m_pa <= 0; m_pb <= 0; m_tmo <= 0; m_on <= 0;
        end else if (!m_on || !en_cfg) begin
            m_cnt <= 0; m_pa <= 0; m_pb <= 0; m_tmo <= 0; m_on <= en_cfg;
        end else begin
            if (dual_mode) begin
                pa = pa | clr_a;
                pb = pb | clr_b;
                if (pa && pb) begin
                    clr = 1; pa = 0; pb = 0;
                end
            end else begin
                clr = clr_single;
                pa = 0; pb = 0;
            end
            m_pa <= pa; m_pb <= pb;
            if (clr) begin
                m_cnt <= 0; m_tmo <= 0;
            end else if (m_cnt == period_of(exp_sel) - 1) begin
                m_cnt <= 0; m_tmo <= 1;
            end else begin
                m_cnt <= m_cnt + 1; m_tmo <= 0;
            end
        end
    end

    // compare on every clock, away from the edge
    always @(negedge clk) begin
        checks++;
        if (tmo_pulse !== m_tmo) begin
            fails++;
            $display("FAIL %s: tmo_pulse=%b expected %b at %0t", req, tmo_pulse, m_tmo, $time);
        end
        if (tmo_pulse === 1'b1) pulses++;
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        clr_single = (which == 0);
        clr_a = (which == 1) || (which == 3);
        clr_b = (which == 2) || (which == 3);
        @(negedge clk);
        clr_single = 0; clr_a = 0; clr_b = 0;
    endtask

    task automatic expect_pulses(input string r, input int exp_n);
        checks++;
        if (pulses != exp_n) begin
            fails++;
            $display("FAIL %s: pulse count %0d expected %0d", r, pulses, exp_n);
        end
    endtask

    task automatic restart(input bit en, input logic [1:0] code, input bit dual);
        @(negedge clk);
        rst = 1; en_cfg = en; exp_sel = code; dual_mode = dual;
        idle(2);
        rst = 0;
        pulses = 0;
    endtask

    initial begin
        idle(3);
        req = "R8";
        checks++;
        if (tmo_pulse !== 1'b0) begin
            fails++;
            $display("FAIL R8: tmo_pulse=%b expected 0 in reset", tmo_pulse);
        end

        // R1/R2: period for each exponent code
        for (int k = 0; k < 4; k++) begin
            req = "R1";
            restart(1, 2'(k), 0);
            idle(2 * period_of(2'(k)) + 5);
            expect_pulses("R1", 2);
        end

        // R3: disabled stays silent, re-enable starts a full period
        req = "R3";
        restart(0, 2'd0, 0);
        idle(3000);
        expect_pulses("R3", 0);
        en_cfg = 1;
        idle(250);
        expect_pulses("R3", 0);
        idle(20);
        expect_pulses("R3", 1);

        // R4: single-clear mode feeds with clr_single, ignores paired strobes
        req = "R4";
        restart(1, 2'd0, 0);
        for (int i = 0; i < 6; i++) begin idle(200); strobe(0); end
        expect_pulses("R4", 0);
        pulses = 0;
        for (int i = 0; i < 10; i++) begin idle(100); strobe(3); end
        checks++;
        if (pulses == 0) begin
            fails++;
            $display("FAIL R4: pulse count %0d expected >0", pulses);
        end

        // R5: paired clear, both orders and same cycle
        req = "R5";
        restart(1, 2'd0, 1);
        for (int i = 0; i < 4; i++) begin idle(100); strobe(1); idle(50); strobe(2); end
        for (int i = 0; i < 4; i++) begin idle(100); strobe(2); idle(50); strobe(1); end
        for (int i = 0; i < 4; i++) begin idle(200); strobe(3); end
        expect_pulses("R5", 0);

        // R6: lone repeated strobe and clr_single do not feed in paired mode
        req = "R6";
        restart(1, 2'd0, 1);
        for (int i = 0; i < 12; i++) begin idle(50); strobe(1); end
        expect_pulses("R6", 2);
        restart(1, 2'd0, 1);
        for (int i = 0; i < 12; i++) begin idle(50); strobe(0); end
        expect_pulses("R6", 2);

        // R7: clear landing on the terminal cycle suppresses the pulse
        req = "R7";
        restart(1, 2'd0, 0);
        while (m_cnt != 254) @(negedge clk);
        @(negedge clk);
        clr_single = 1;
        @(negedge clk);
        clr_single = 0;
        idle(10);
        expect_pulses("R7", 0);
        idle(260);
        expect_pulses("R7", 1);

        // R8: mid-count reset restarts a full period, pending mark dropped
        req = "R8";
        restart(1, 2'd0, 1);
        idle(200);
        strobe(1);
        @(negedge clk); rst = 1; @(negedge clk); rst = 0;
        pulses = 0;
        strobe(2);
        idle(240);
        expect_pulses("R8", 0);
        idle(30);
        expect_pulses("R8", 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule